// File: doc/BRIEF.md
# Sequential Signed Fractional Multiplier

This unit multiplies two signed 16-bit two's-complement operands over several clock cycles. One operand is the selected source value. The other is always the value of general register 6. The 32-bit product is built from four passes through a single 8x8 multiplier. Each pass multiplies one byte of each operand. The partial product is shifted to its byte position and added into a 32-bit accumulator.

In fractional mode, product bits 31:16 are written to the destination register and product bit 15 goes to the carry flag. The low fifteen bits are dropped. A mode input selects the long-multiply variant, which uses the same datapath and also presents the low half of the product.

A configuration input picks the short schedule (4 cycles) or the long one (8 cycles, one pass every two cycles). The unit asks for no register write when the destination index is 4. On completion it pulses a request that returns the prefix state to its cleared default.

Operands, the destination index, the mode and the speed setting are captured when a start is accepted. The caller supplies the destination index, using register 0 when nothing was preselected. Instruction decoding and the register file sit outside the block.

Top module: `sfrac_mul_unit`

## Requirements
- R1: When `done_o` is high, `wr_data_o` equals bits 31:16 of the signed 32-bit product of `src_i` and `r6_i` captured at the accepted start.
- R2: When `done_o` is high, `carry_o` equals bit 15 of that product.
- R3: When `done_o` is high, `flag_we_o` is high, `sign_o` equals bit 15 of `wr_data_o`, and `zero_o` is 1 exactly when `wr_data_o` is 0.
- R4: The product is exact for all operand signs and extremes, including 0x8000 times 0x8000, as required when it is built from four byte passes.
- R5: With `slow_i` = 0 at start, `done_o` is high in the 4th cycle after the start edge. With `slow_i` = 1, it is high in the 8th cycle. It is low in every earlier cycle.
- R6: When the captured destination index is 4, `wr_en_o` stays low while `done_o` still pulses. For any other index, `wr_en_o` pulses with `done_o` and `wr_idx_o` equals that index.
- R7: `busy_o` is high from the cycle after an accepted start up to and including the `done_o` cycle, then falls. `done_o` lasts exactly one cycle. A start while busy is ignored and does not change the result or extend the operation.
- R8: With `mode_i` = 1 (long), `lo_data_o` equals product bits 15:0 in the `done_o` cycle. With `mode_i` = 0 (fractional), `lo_data_o` is 0.
- R9: `alt_clr_o` is high exactly in the `done_o` cycle.
- R10: After reset, `busy_o`, `done_o` and `wr_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| mode_i | input | 1 | 0 = fractional, 1 = long multiply |
| slow_i | input | 1 | 0 = 4-cycle schedule, 1 = 8-cycle schedule |
| src_i | input | 16 | Source operand, signed |
| r6_i | input | 16 | Value of general register 6, signed |
| dst_i | input | 4 | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Register write request |
| wr_idx_o | output | 4 | Register write index |
| wr_data_o | output | 16 | Product bits 31:16 |
| lo_data_o | output | 16 | Product bits 15:0 in long mode, else 0 |
| carry_o | output | 1 | Carry flag value (product bit 15) |
| sign_o | output | 1 | Sign flag value |
| zero_o | output | 1 | Zero flag value |
| flag_we_o | output | 1 | Flag update strobe |
| alt_clr_o | output | 1 | Request to clear the prefix state |

## Verification
The embedded assertions check the handshake on every cycle:
- `done_o` is a single-cycle pulse inside the busy window, and busy falls right after it.
- The count of busy cycles matches the captured speed setting.
- No write request ever targets register 4.
- The accumulator is never cleared and advanced in the same cycle.

Arithmetic correctness needs the bench scenarios. These include the worked example 0x4AAA times 0xDAAB giving 0xF51C with carry and sign set, the extreme negative operands, zero and near-zero results, long-mode low halves, and starts issued mid-operation. Random operands run under both schedules and both modes.

// File: rtl/smul_pkg.sv
package smul_pkg;

   typedef enum logic {
      SMUL_FRAC = 1'b0,
      SMUL_LONG = 1'b1
   } smul_mode_e;

   // byte-pair order of the four passes
   typedef enum logic [1:0] {
      PASS_LL = 2'd0,
      PASS_HL = 2'd1,
      PASS_LH = 2'd2,
      PASS_HH = 2'd3
   } smul_pass_e;

endpackage

// File: rtl/smul_byte_mul.sv
module smul_byte_mul #(
   parameter int H         = 8,
   parameter int MUL_STYLE = 0   // 0: direct operator, 1: shift-add array
) (
   input  logic [H-1:0]          a_i,
   input  logic                  a_sgn_i,
   input  logic [H-1:0]          b_i,
   input  logic                  b_sgn_i,
   output logic signed [2*H+1:0] p_o
);
   localparam int PW = 2*H + 2;

   logic signed [H:0] ae;
   logic signed [H:0] be;

   assign ae = {a_sgn_i & a_i[H-1], a_i};
   assign be = {b_sgn_i & b_i[H-1], b_i};

   generate
      if (MUL_STYLE == 0) begin : g_direct
         assign p_o = PW'(ae) * PW'(be);
      end else begin : g_array
         logic signed [PW-1:0] ax;
         logic signed [PW-1:0] sum;
         assign ax = {{(H+1){ae[H]}}, ae};
         always_comb begin
            sum = '0;
            for (int i = 0; i < H; i++) begin
               if (be[i]) sum = sum + (ax <<< i);
            end
            if (be[H]) sum = sum - (ax <<< H);
         end
         assign p_o = sum;
      end
   endgenerate

   initial begin
      if (H < 2) $error("smul_byte_mul: H must be at least 2");
      if (MUL_STYLE != 0 && MUL_STYLE != 1) $error("smul_byte_mul: bad MUL_STYLE");
   end
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
   import smul_pkg::*;
#(
   parameter int FAST_CYC = 4,
   parameter int SLOW_CYC = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       slow_i,
   output logic       launch_o,
   output logic       busy_o,
   output logic       acc_en_o,
   output logic       last_o,
   output smul_pass_e pass_o
);
   localparam int CW  = (SLOW_CYC > 2) ? $clog2(SLOW_CYC) : 1;
   localparam int FPP = FAST_CYC / 4;
   localparam int SPP = SLOW_CYC / 4;

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          slow_q;
   logic [CW-1:0] sub;
   logic [CW-1:0] sub_end;
   logic [CW-1:0] cnt_end;

   assign launch_o = start_i & ~busy_q;
   assign cnt_end  = slow_q ? CW'(SLOW_CYC - 1) : CW'(FAST_CYC - 1);
   assign last_o   = busy_q && (cnt_q == cnt_end);
   assign sub      = slow_q ? (cnt_q % CW'(SPP)) : (cnt_q % CW'(FPP));
   assign sub_end  = slow_q ? CW'(SPP - 1) : CW'(FPP - 1);
   assign acc_en_o = busy_q && (sub == sub_end);
   assign pass_o   = smul_pass_e'(slow_q ? 2'(cnt_q / CW'(SPP)) : 2'(cnt_q / CW'(FPP)));
   assign busy_o   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         slow_q <= 1'b0;
      end else if (launch_o) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         slow_q <= slow_i;
      end else if (busy_q) begin
         if (last_o) busy_q <= 1'b0;
         else        cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R7: completion is a single pulse, inside the busy window, followed by idle
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !last_o);
   a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> !busy_o);
   a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> busy_o);
   // R5: the operand of the speed setting cannot change mid-operation
   a_r5_slow_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !last_o) |=> $stable(slow_q));

   initial begin
      if (FAST_CYC < 4 || FAST_CYC % 4 != 0) $error("smul_ctrl: FAST_CYC must be a multiple of 4");
      if (SLOW_CYC % 4 != 0) $error("smul_ctrl: SLOW_CYC must be a multiple of 4");
      if (SLOW_CYC < FAST_CYC) $error("smul_ctrl: SLOW_CYC below FAST_CYC");
   end
endmodule

// File: rtl/smul_acc.sv
module smul_acc #(
   parameter int AW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 en_i,
   input  logic signed [AW-1:0] pp_i,
   output logic signed [AW-1:0] sum_o
);
   logic signed [AW-1:0] acc_q;

   assign sum_o = acc_q + pp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= sum_o;
   end

   // R4: a fresh operation never overlaps an accumulating pass
   a_r4_clear_not_accum: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |-> !en_i);

   initial begin
      if (AW < 4) $error("smul_acc: AW too small");
   end
endmodule

// File: rtl/sfrac_mul_unit.sv
module sfrac_mul_unit
   import smul_pkg::*;
#(
   parameter int W            = 16,
   parameter int IW           = 4,
   parameter int FAST_CYC     = 4,
   parameter int SLOW_CYC     = 8,
   parameter int NO_WRITE_IDX = 4,
   parameter int MUL_STYLE    = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_i,
   input  logic          slow_i,
   input  logic [W-1:0]  src_i,
   input  logic [W-1:0]  r6_i,
   input  logic [IW-1:0] dst_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          wr_en_o,
   output logic [IW-1:0] wr_idx_o,
   output logic [W-1:0]  wr_data_o,
   output logic [W-1:0]  lo_data_o,
   output logic          carry_o,
   output logic          sign_o,
   output logic          zero_o,
   output logic          flag_we_o,
   output logic          alt_clr_o
);
   localparam int H  = W / 2;
   localparam int AW = 2 * W;
   localparam int LW = $clog2(SLOW_CYC + 1);

   logic           launch, acc_en, last;
   smul_pass_e     pass;
   logic [W-1:0]   a_q, b_q;
   logic [IW-1:0]  dst_q;
   smul_mode_e     mode_q;
   logic [H-1:0]   ax, bx;
   logic           as_, bs_;
   logic signed [W+1:0]  pbyte;
   logic signed [AW-1:0] pwide, pp;
   logic signed [AW-1:0] prod;

   smul_ctrl #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .slow_i(slow_i),
      .launch_o(launch), .busy_o(busy_o), .acc_en_o(acc_en),
      .last_o(last), .pass_o(pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         dst_q  <= '0;
         mode_q <= SMUL_FRAC;
      end else if (launch) begin
         a_q    <= src_i;
         b_q    <= r6_i;
         dst_q  <= dst_i;
         mode_q <= smul_mode_e'(mode_i);
      end
   end

   // byte selection: upper bytes signed, lower bytes unsigned
   always_comb begin
      case (pass)
         PASS_LL: begin ax = a_q[H-1:0]; as_ = 1'b0; bx = b_q[H-1:0]; bs_ = 1'b0; end
         PASS_HL: begin ax = a_q[W-1:H]; as_ = 1'b1; bx = b_q[H-1:0]; bs_ = 1'b0; end
         PASS_LH: begin ax = a_q[H-1:0]; as_ = 1'b0; bx = b_q[W-1:H]; bs_ = 1'b1; end
         default: begin ax = a_q[W-1:H]; as_ = 1'b1; bx = b_q[W-1:H]; bs_ = 1'b1; end
      endcase
   end

   smul_byte_mul #(.H(H), .MUL_STYLE(MUL_STYLE)) bmul_i (
      .a_i(ax), .a_sgn_i(as_), .b_i(bx), .b_sgn_i(bs_), .p_o(pbyte)
   );

   assign pwide = {{(AW-W-2){pbyte[W+1]}}, pbyte};

   always_comb begin
      case (pass)
         PASS_LL:          pp = pwide;
         PASS_HL, PASS_LH: pp = pwide <<< H;
         default:          pp = pwide <<< W;
      endcase
   end

   smul_acc #(.AW(AW)) acc_i (
      .clk(clk), .rst_n(rst_n), .clr_i(launch), .en_i(acc_en),
      .pp_i(pp), .sum_o(prod)
   );

   assign done_o    = last;
   assign flag_we_o = last;
   assign alt_clr_o = last;
   assign wr_idx_o  = dst_q;
   assign wr_en_o   = last && (dst_q != IW'(NO_WRITE_IDX));
   assign wr_data_o = prod[AW-1:W];
   assign carry_o   = prod[W-1];
   assign sign_o    = prod[AW-1];
   assign zero_o    = (prod[AW-1:W] == '0);
   assign lo_data_o = (mode_q == SMUL_LONG) ? prod[W-1:0] : '0;

   // checker state: cycles since the accepted start
   logic [LW-1:0] lat_q;
   logic          slow_chk_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q      <= '0;
         slow_chk_q <= 1'b0;
      end else if (launch) begin
         lat_q      <= LW'(1);
         slow_chk_q <= slow_i;
      end else if (busy_o && !done_o) begin
         lat_q      <= lat_q + 1'b1;
      end
   end

   // R5: done arrives after exactly the configured number of cycles
   a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == (slow_chk_q ? LW'(SLOW_CYC) : LW'(FAST_CYC))));
   // R6: the reserved index is never written
   a_r6_no_write_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_idx_o != IW'(NO_WRITE_IDX)));
   // R7: outputs of completion only appear inside the busy window
   a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   initial begin
      if (W < 4 || W % 2 != 0) $error("sfrac_mul_unit: W must be even and at least 4");
      if (NO_WRITE_IDX >= (1 << IW)) $error("sfrac_mul_unit: NO_WRITE_IDX out of range");
   end
endmodule

// File: tb/sfrac_mul_unit_tb_top.sv
`timescale 1ns/1ps
module sfrac_mul_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, mode_i = 1'b0, slow_i = 1'b0;
   logic [15:0] src_i = '0, r6_i = '0;
   logic [3:0]  dst_i = '0;
   logic        busy_o, done_o, wr_en_o, carry_o, sign_o, zero_o, flag_we_o, alt_clr_o;
   logic [3:0]  wr_idx_o;
   logic [15:0] wr_data_o, lo_data_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   sfrac_mul_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .slow_i(slow_i),
      .src_i(src_i), .r6_i(r6_i), .dst_i(dst_i), .busy_o(busy_o), .done_o(done_o),
      .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .lo_data_o(lo_data_o),
      .carry_o(carry_o), .sign_o(sign_o), .zero_o(zero_o), .flag_we_o(flag_we_o),
      .alt_clr_o(alt_clr_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_prod(input logic [15:0] a, input logic [15:0] b);
      int pa, pb;
      pa = int'($signed(a));
      pb = int'($signed(b));
      return 32'(pa * pb);
   endfunction

   task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [3:0] d,
                         input bit lng, input bit slw, input bit inject);
      logic [31:0] p;
      int n;
      bit early;
      p = ref_prod(a, b);
      n = slw ? 8 : 4;
      early = 0;
      @(negedge clk);
      src_i = a; r6_i = b; dst_i = d; mode_i = lng; slow_i = slw; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < n - 1; i++) begin
         if (done_o !== 1'b0 || busy_o !== 1'b1 || wr_en_o !== 1'b0) early = 1;
         if (inject && i == 0) begin
            start_i = 1'b1; src_i = ~a; r6_i = a ^ 16'h5a5a; dst_i = d + 4'd1;
            mode_i = ~lng; slow_i = ~slw;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      chk(!early, "R5 no done before final cycle", 32'(early), 32'd0);
      chk(done_o === 1'b1, "R5 done in final cycle", 32'(done_o), 32'd1);
      chk(wr_data_o === p[31:16], "R1 result high half", 32'(wr_data_o), 32'(p[31:16]));
      chk(carry_o === p[15], "R2 carry is product bit 15", 32'(carry_o), 32'(p[15]));
      chk(sign_o === p[31] && flag_we_o === 1'b1, "R3 sign flag", {sign_o, flag_we_o}, {p[31], 1'b1});
      chk(zero_o === (p[31:16] == 16'd0), "R3 zero flag", 32'(zero_o), 32'(p[31:16] == 16'd0));
      if (d == 4'd4)
         chk(wr_en_o === 1'b0, "R6 index 4 not written", 32'(wr_en_o), 32'd0);
      else
         chk(wr_en_o === 1'b1 && wr_idx_o === d, "R6 write to index", {wr_en_o, wr_idx_o}, {1'b1, d});
      chk(lo_data_o === (lng ? p[15:0] : 16'd0), "R8 low half by mode", 32'(lo_data_o),
          32'(lng ? p[15:0] : 16'd0));
      chk(alt_clr_o === 1'b1, "R9 prefix clear with done", 32'(alt_clr_o), 32'd1);
      @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0 && alt_clr_o === 1'b0, "R7 idle after done, start while busy ignored",
          {busy_o, done_o, alt_clr_o}, 32'd0);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(busy_o === 1'b0 && done_o === 1'b0 && wr_en_o === 1'b0, "R10 reset state",
          {busy_o, done_o, wr_en_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R2 R3: worked example, result f51c with carry and sign set
      run_op(16'h4AAA, 16'hDAAB, 4'd2, 1'b0, 1'b0, 1'b0);
      run_op(16'h4AAA, 16'hDAAB, 4'd2, 1'b1, 1'b1, 1'b0);
      // R4: extremes
      run_op(16'h8000, 16'h8000, 4'd1, 1'b1, 1'b0, 1'b0);
      run_op(16'h8000, 16'h7FFF, 4'd3, 1'b0, 1'b1, 1'b0);
      run_op(16'h7FFF, 16'h7FFF, 4'd15, 1'b1, 1'b0, 1'b0);
      run_op(16'hFFFF, 16'hFFFF, 4'd0, 1'b1, 1'b0, 1'b0);
      run_op(16'h0000, 16'hABCD, 4'd7, 1'b0, 1'b1, 1'b0);
      run_op(16'hFFFF, 16'h0001, 4'd5, 1'b1, 1'b1, 1'b0);
      // R6: reserved index, both speeds
      run_op(16'h1234, 16'h5678, 4'd4, 1'b0, 1'b0, 1'b0);
      run_op(16'hF00D, 16'h0BAD, 4'd4, 1'b1, 1'b1, 1'b0);
      // R7: start while busy
      run_op(16'h2222, 16'hC003, 4'd9, 1'b0, 1'b0, 1'b1);
      run_op(16'h9999, 16'h0707, 4'd11, 1'b1, 1'b1, 1'b1);
      // random mix
      void'($urandom(32'd20240731));
      for (int k = 0; k < 160; k++) begin
         logic [15:0] ra, rb;
         logic [3:0]  rd;
         ra = 16'($urandom);
         rb = 16'($urandom);
         rd = 4'($urandom);
         run_op(ra, rb, rd, 1'($urandom), 1'($urandom), ($urandom % 8) == 0);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule